// File: doc/BRIEF.md
# Pointer-Indexed Host Register Port

This block is the host-facing access path to a small byte RAM that is shared with a sound engine. The host sees only three locations on a CPU-style bus. A select location loads a byte pointer into the RAM and a step flag. A data location reads or writes the RAM byte under the pointer. A control location latches a global sound-off bit. When the step flag is set, each data access moves the pointer on by one. This lets the host stream a whole run of RAM bytes through the single data location.

The RAM itself sits outside the block. The port drives its address, write enable and write data, and it samples its combinational read data. Two compatibility options are set by parameter, and both act only on the bytes of voices that are active. The first drops writes to the phase bytes of a voice while the pointer still steps. The second forces the three top bits high on the length byte of a voice. To know which voices are active, the port keeps its own copy of the voice-count field, taken from host writes to the last RAM byte.

Top module: `indirect_reg_port`

## Requirements
- R1: A write to address 0xE000 sets the `sound_off` output to data bit 6. The new value appears after the clock edge that takes the write.
- R2: A write to address 0xF800 loads the pointer from data bits 6:0 and the step flag from data bit 7. `ram_addr` always shows the pointer.
- R3: A write to address 0x4800 drives `ram_we` high for that cycle, with `ram_addr` equal to the pointer and `ram_wdata` equal to the host data, except where R9 or R10 applies.
- R4: A read from address 0x4800 returns the RAM byte under the pointer on `host_rdata`. The byte is sampled in the read cycle and held until the next data read.
- R5: When the step flag is set, every data access, read or write, leaves the pointer at (pointer + 1) mod 128. From 127 it goes to 0.
- R6: When the step flag is clear, data accesses leave the pointer unchanged.
- R7: A strobe to any other address, or a read of 0xE000 or 0xF800, gets no acknowledge. It leaves the pointer, the step flag, `sound_off` and the RAM unchanged.
- R8: After reset the pointer is 0, the step flag is clear, `sound_off` is 0, `host_ack` is 0 and the voice count is one.
- R9: With PROTECT_PHASE set, a data write whose pointer offset within its 8-byte voice block is 1, 3 or 5, in an active block, does not write the RAM. The access is still acknowledged and the pointer still steps.
- R10: With FORCE_LEN_HIGH set, a data write at block offset 4 of an active block stores the data with bits 7:5 forced to 1.
- R11: Active voices come from bits 6:4 of the last host data write to byte 127. With that field equal to n, there are n+1 active voices. They occupy the top n+1 blocks, so block b (pointer bits 6:3) is active when b + n >= 15. Inactive blocks take plain writes.
- R12: `host_ack` is high for exactly the cycle after each accepted access (R1 to R4). When a host read and a host write arrive in the same cycle, the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 16 | Host bus address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_ack | output | 1 | Access accepted, one cycle after the strobe |
| host_rdata | output | 8 | Read data of the last data read |
| ram_addr | output | 7 | RAM address (the pointer) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM combinational read data at `ram_addr` |
| sound_off | output | 1 | Latched global sound-off bit |

## Verification
The bench aims at the pointer wrapping from 127 to 0. A design that saturated there, or carried into an eighth bit, would leave `ram_addr` stuck or wrong. It checks that a data read steps the pointer just as a write does; a design that stepped on writes only would return the same byte again during a streamed read. The bench also moves the voice count so that the same pointer offsets fall inside and outside the active blocks. This exposes an off-by-one in the active-block test, which would protect or force bytes of silent voices, or miss live ones. Finally, it sends strobes to stray addresses and reads of write-only locations, where a loose decoder would acknowledge the access or disturb the pointer.

// File: rtl/irp_pkg.sv
package irp_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE   = 3'd0,
    ACC_MUTE   = 3'd1,
    ACC_SELECT = 3'd2,
    ACC_PUT    = 3'd3,
    ACC_GET    = 3'd4,
    ACC_STRAY  = 3'd5
  } acc_e;
endpackage

// File: rtl/irp_decode.sv
module irp_decode
  import irp_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]   MUTE_ADDR = 16'hE000,
  parameter logic [ADDR_W-1:0]   SEL_ADDR  = 16'hF800,
  parameter logic [ADDR_W-1:0]   DATA_ADDR = 16'h4800
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  output acc_e              acc
);
  logic hit_mute, hit_sel, hit_data;

  assign hit_mute = (host_addr == MUTE_ADDR);
  assign hit_sel  = (host_addr == SEL_ADDR);
  assign hit_data = (host_addr == DATA_ADDR);

  // write wins over a simultaneous read
  always_comb begin
    acc = ACC_IDLE;
    if (host_wr) begin
      if (hit_mute)      acc = ACC_MUTE;
      else if (hit_sel)  acc = ACC_SELECT;
      else if (hit_data) acc = ACC_PUT;
      else               acc = ACC_STRAY;
    end else if (host_rd) begin
      if (hit_data) acc = ACC_GET;
      else          acc = ACC_STRAY;
    end
  end
endmodule

// File: rtl/irp_pointer.sv
module irp_pointer
  import irp_pkg::*;
#(
  parameter int unsigned PTR_W    = 7,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MUTE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              step_en,
  output logic              mute
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_d;
  logic             step_d, mute_d;
  logic             ptr_ce, step_ce, mute_ce;
  logic             data_acc;

  assign data_acc = (acc == ACC_PUT) || (acc == ACC_GET);

  always_comb begin
    ptr_ce  = 1'b0;
    step_ce = 1'b0;
    mute_ce = 1'b0;
    ptr_d   = ptr;
    step_d  = step_en;
    mute_d  = mute;
    unique case (acc)
      ACC_SELECT: begin
        ptr_ce  = 1'b1;
        step_ce = 1'b1;
        ptr_d   = wdata[PTR_W-1:0];
        step_d  = wdata[DATA_W-1];
      end
      ACC_PUT, ACC_GET: begin
        ptr_ce = step_en;
        ptr_d  = ptr + PTR_ONE;
      end
      ACC_MUTE: begin
        mute_ce = 1'b1;
        mute_d  = wdata[MUTE_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      step_en <= 1'b0;
      mute    <= 1'b0;
    end else begin
      if (ptr_ce)  ptr     <= ptr_d;
      if (step_ce) step_en <= step_d;
      if (mute_ce) mute    <= mute_d;
    end
  end

  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && step_en) |=> (ptr == PTR_W'($past(ptr) + PTR_ONE)));
  // R6
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !step_en) |=> $stable(ptr));
  // R1
  mute_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_MUTE) |=> (mute == $past(wdata[MUTE_BIT])));
  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_SELECT) |=> (ptr == $past(wdata[PTR_W-1:0]) && step_en == $past(wdata[DATA_W-1])));
endmodule

// File: rtl/irp_wr_filter.sv
module irp_wr_filter
  import irp_pkg::*;
#(
  parameter int unsigned PTR_W          = 7,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned VOICE_BYTES    = 8,
  parameter int unsigned VCNT_LSB       = 4,
  parameter bit          PROTECT_PHASE  = 1'b0,
  parameter bit          FORCE_LEN_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int unsigned OFF_W      = $clog2(VOICE_BYTES);
  localparam int unsigned BLK_W      = PTR_W - OFF_W;
  localparam int unsigned NUM_BLOCKS = 1 << BLK_W;
  localparam int unsigned MAX_VOICES = NUM_BLOCKS / 2;
  localparam int unsigned VCNT_W     = $clog2(MAX_VOICES);
  localparam logic [PTR_W-1:0]  CNT_BYTE = {PTR_W{1'b1}};
  localparam logic [OFF_W-1:0]  LEN_OFF  = OFF_W'(4);
  localparam logic [BLK_W:0]    LAST_BLK = (BLK_W+1)'(NUM_BLOCKS - 1);
  localparam logic [DATA_W-1:0] LEN_MASK = {3'b111, {(DATA_W-3){1'b0}}};

  logic [VCNT_W-1:0] vcnt, vcnt_d;
  logic              vcnt_ce;
  logic [BLK_W-1:0]  blk;
  logic [OFF_W-1:0]  off;
  logic [BLK_W:0]    blk_sum;
  logic              active, phase_off, len_off;
  logic              drop, force_hi;
  logic              put;

  assign put     = (acc == ACC_PUT);
  assign blk     = ptr[PTR_W-1:OFF_W];
  assign off     = ptr[OFF_W-1:0];
  assign blk_sum = {1'b0, blk} + {{(BLK_W+1-VCNT_W){1'b0}}, vcnt};
  assign active  = (blk_sum >= LAST_BLK);
  assign phase_off = (off == OFF_W'(1)) || (off == OFF_W'(3)) || (off == OFF_W'(5));
  assign len_off   = (off == LEN_OFF);

  generate
    if (PROTECT_PHASE) begin : g_protect
      assign drop = active && phase_off;
    end else begin : g_no_protect
      assign drop = 1'b0;
    end
    if (FORCE_LEN_HIGH) begin : g_force
      assign force_hi = active && len_off;
    end else begin : g_no_force
      assign force_hi = 1'b0;
    end
  endgenerate

  assign ram_we    = put && !drop;
  assign ram_wdata = force_hi ? (wdata | LEN_MASK) : wdata;

  // shadow of the voice-count field
  always_comb begin
    vcnt_ce = put && (ptr == CNT_BYTE);
    vcnt_d  = wdata[VCNT_LSB +: VCNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt <= '0;
    else if (vcnt_ce) vcnt <= vcnt_d;
  end

  // R11
  vcnt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put && ptr == CNT_BYTE) |=> (vcnt == $past(wdata[VCNT_LSB +: VCNT_W])));
  // R9
  phase_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && PROTECT_PHASE && active) |-> !phase_off);
  // R10
  len_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && FORCE_LEN_HIGH && active && len_off) |-> (ram_wdata[DATA_W-1 -: 3] == 3'b111));
  // R3
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put && !active) |-> (ram_we && ram_wdata == wdata));
endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port
  import irp_pkg::*;
#(
  parameter int unsigned  ADDR_W         = 16,
  parameter int unsigned  DATA_W         = 8,
  parameter int unsigned  PTR_W          = 7,
  parameter int unsigned  VOICE_BYTES    = 8,
  parameter int unsigned  MUTE_BIT       = 6,
  parameter int unsigned  VCNT_LSB       = 4,
  parameter logic [15:0]  MUTE_ADDR      = 16'hE000,
  parameter logic [15:0]  SEL_ADDR       = 16'hF800,
  parameter logic [15:0]  DATA_ADDR      = 16'h4800,
  parameter bit           PROTECT_PHASE  = 1'b0,
  parameter bit           FORCE_LEN_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              sound_off
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  acc_e                   acc;
  logic [PTR_W-1:0]       ptr;
  logic                   step_en;
  logic                   ack_d, rdata_ce;
  logic [DATA_W-1:0]      rdata_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  irp_decode #(
    .ADDR_W(ADDR_W), .MUTE_ADDR(ADDR_W'(MUTE_ADDR)),
    .SEL_ADDR(ADDR_W'(SEL_ADDR)), .DATA_ADDR(ADDR_W'(DATA_ADDR))
  ) u_decode (
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr), .acc(acc)
  );

  irp_pointer #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .MUTE_BIT(MUTE_BIT)
  ) u_pointer (
    .clk(clk), .rst_n(rst_int_n), .acc(acc), .wdata(host_wdata),
    .ptr(ptr), .step_en(step_en), .mute(sound_off)
  );

  irp_wr_filter #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .VOICE_BYTES(VOICE_BYTES),
    .VCNT_LSB(VCNT_LSB), .PROTECT_PHASE(PROTECT_PHASE),
    .FORCE_LEN_HIGH(FORCE_LEN_HIGH)
  ) u_filter (
    .clk(clk), .rst_n(rst_int_n), .acc(acc), .ptr(ptr), .wdata(host_wdata),
    .ram_we(ram_we), .ram_wdata(ram_wdata)
  );

  assign ram_addr = ptr;

  always_comb begin
    ack_d    = (acc != ACC_IDLE) && (acc != ACC_STRAY);
    rdata_ce = (acc == ACC_GET);
    rdata_d  = ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= ack_d;
      if (rdata_ce) host_rdata <= rdata_d;
    end
  end

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_wr && (host_addr == ADDR_W'(MUTE_ADDR) || host_addr == ADDR_W'(SEL_ADDR)
                 || host_addr == ADDR_W'(DATA_ADDR))) |=> host_ack);
  // R7
  stray_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc == ACC_STRAY) |=> (!host_ack && $stable(ptr) && $stable(step_en) && $stable(sound_off)));
  // R7
  stray_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc == ACC_STRAY) |-> !ram_we);
  // R4
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_rd && !host_wr && host_addr == ADDR_W'(DATA_ADDR)) |=> (host_rdata == $past(ram_rdata)));
endmodule

// File: tb/tb_indirect_reg_port.sv
module tb_indirect_reg_port;
  localparam int unsigned WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;

  logic       ack_q, ack_p, we_q, we_p, off_q, off_p;
  logic [7:0] rdata_q, rdata_p, wd_q, wd_p, rd_q, rd_p;
  logic [6:0] addr_q, addr_p;

  logic [7:0] ram_q [128];
  logic [7:0] ram_p [128];
  logic [7:0] mdl_q [128];
  logic [7:0] mdl_p [128];
  logic [6:0] m_ptr;
  logic       m_step, m_off;
  logic [2:0] m_vcnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  indirect_reg_port #(.PROTECT_PHASE(1'b1), .FORCE_LEN_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_ack(ack_q), .host_rdata(rdata_q),
    .ram_addr(addr_q), .ram_we(we_q), .ram_wdata(wd_q), .ram_rdata(rd_q),
    .sound_off(off_q));

  indirect_reg_port dut_plain (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_ack(ack_p), .host_rdata(rdata_p),
    .ram_addr(addr_p), .ram_we(we_p), .ram_wdata(wd_p), .ram_rdata(rd_p),
    .sound_off(off_p));

  assign rd_q = ram_q[addr_q];
  assign rd_p = ram_p[addr_p];
  always @(posedge clk) begin
    if (we_q) ram_q[addr_q] <= wd_q;
    if (we_p) ram_p[addr_p] <= wd_p;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // R11: active when block + count field >= 15
  function automatic bit blk_active(input logic [6:0] p, input logic [2:0] n);
    return (int'(p[6:3]) + int'(n)) >= 15;
  endfunction

  // R9/R10 expectation: bit 8 = stored, bits 7:0 = value
  function automatic logic [8:0] quirk_store(input logic [6:0] p, input logic [7:0] d,
                                             input logic [2:0] n);
    logic [2:0] o;
    o = p[2:0];
    if (blk_active(p, n) && (o == 3'd1 || o == 3'd3 || o == 3'd5)) return {1'b0, d};
    if (blk_active(p, n) && o == 3'd4) return {1'b1, d | 8'hE0};
    return {1'b1, d};
  endfunction

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rd,
                     input logic wr, input string req);
    bit exp_ack, is_get;
    logic [7:0] exp_rq, exp_rp;
    logic [8:0] qs;
    exp_ack = 0; is_get = 0; exp_rq = '0; exp_rp = '0;
    @(negedge clk);
    host_addr = a; host_wdata = d; host_rd = rd; host_wr = wr;
    if (wr) begin
      if (a == 16'hE000) begin exp_ack = 1; m_off = d[6]; end
      else if (a == 16'hF800) begin exp_ack = 1; m_ptr = d[6:0]; m_step = d[7]; end
      else if (a == 16'h4800) begin
        exp_ack = 1;
        qs = quirk_store(m_ptr, d, m_vcnt);
        if (qs[8]) mdl_q[m_ptr] = qs[7:0];
        mdl_p[m_ptr] = d;
        if (m_ptr == 7'h7F) m_vcnt = d[6:4];
        if (m_step) m_ptr = m_ptr + 7'd1;
      end
    end else if (rd && a == 16'h4800) begin
      exp_ack = 1; is_get = 1;
      exp_rq = mdl_q[m_ptr]; exp_rp = mdl_p[m_ptr];
      if (m_step) m_ptr = m_ptr + 7'd1;
    end
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    check(ack_q == exp_ack && ack_p == exp_ack, exp_ack ? "R12" : "R7", "ack",
          {ack_q, ack_p}, {exp_ack, exp_ack});
    check(addr_q == m_ptr && addr_p == m_ptr, req, "pointer", addr_q, m_ptr);
    check(off_q == m_off && off_p == m_off, "R1", "sound_off", {off_q, off_p}, {m_off, m_off});
    if (is_get) begin
      check(rdata_q == exp_rq, req, "rdata quirk", rdata_q, exp_rq);
      check(rdata_p == exp_rp, req, "rdata plain", rdata_p, exp_rp);
    end
  endtask

  task automatic sel(input logic [7:0] v, input string req);
    bus(16'hF800, v, 1'b0, 1'b1, req);
  endtask
  task automatic put(input logic [7:0] v, input string req);
    bus(16'h4800, v, 1'b0, 1'b1, req);
  endtask
  task automatic get(input string req);
    bus(16'h4800, 8'h00, 1'b1, 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) begin
      ram_q[i] = 8'($urandom); ram_p[i] = ram_q[i];
      mdl_q[i] = ram_q[i]; mdl_p[i] = ram_q[i];
    end
    m_ptr = '0; m_step = 0; m_off = 0; m_vcnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    check(ack_q == 0 && ack_p == 0, "R8", "ack", ack_q, 0);
    check(addr_q == 0 && addr_p == 0, "R8", "pointer", addr_q, 0);
    check(off_q == 0 && off_p == 0, "R8", "sound_off", off_q, 0);
    get("R8");                     // step flag clear: pointer stays 0
    // R1
    bus(16'hE000, 8'h40, 0, 1, "R1");
    bus(16'hE000, 8'hBF, 0, 1, "R1");
    bus(16'hE000, 8'h40, 0, 1, "R1");
    // R2, R3, R5
    sel(8'h85, "R2");
    put(8'h3C, "R3");
    put(8'hC3, "R5");
    sel(8'h05, "R6");
    get("R4"); get("R6");
    // R5 wrap 127 -> 0, reads also step
    sel(8'hFE, "R5");
    get("R5"); get("R5"); get("R5");
    // R7 strays and reads of write-only locations
    bus(16'h1234, 8'hFF, 0, 1, "R7");
    bus(16'hE000, 8'h00, 1, 0, "R7");
    bus(16'hF800, 8'h00, 1, 0, "R7");
    bus(16'h4801, 8'h55, 0, 1, "R7");
    // R12 read and write together: write taken
    bus(16'h4800, 8'h77, 1, 1, "R12");
    // R9 with one voice (block 15)
    sel(8'hF9, "R9"); put(8'hAA, "R9"); put(8'hAB, "R9"); put(8'hAC, "R9");
    put(8'hAD, "R9");
    sel(8'hF9, "R9"); get("R9"); get("R9"); get("R9"); get("R9");
    // R11 eight voices: block 8 becomes active
    sel(8'h7F, "R11"); put(8'h70, "R11");
    sel(8'hC1, "R11"); put(8'h11, "R11"); put(8'h22, "R11"); put(8'h33, "R11");
    sel(8'hC1, "R11"); get("R11"); get("R11"); get("R11");
    // R11 back to two voices: block 8 plain again, block 14 active
    sel(8'h7F, "R11"); put(8'h10, "R11");
    sel(8'hC3, "R11"); put(8'h44, "R11"); put(8'h05, "R10");
    sel(8'hC3, "R11"); get("R11"); get("R10");
    sel(8'hF4, "R10"); put(8'h01, "R10");
    sel(8'h74, "R10"); get("R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0: bus(16'hE000, 8'($urandom), 0, 1, "R1");
        1, 2: sel(8'($urandom), "R2");
        3, 4, 5: put(8'($urandom), "R3");
        6, 7, 8: get("R4");
        default: bus(16'($urandom) | 16'h0001, 8'($urandom), 1'($urandom), 1'b1, "R7");
      endcase
    end
    // final sweep of all bytes
    sel(8'h80, "R5");
    for (int i = 0; i < 128; i++) get("R4");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule